// File: doc/BRIEF.md
# SDRAM Burst Write Sequencer

This block runs one write burst of one or more halfwords into a single SDRAM bank. The bank is wired over a 16-bit bus that carries both addresses and data. A requester offers a row, a column and a burst length through a ready/valid request port. The halfwords then arrive one per clock on a second ready/valid port. The sequencer opens the row, issues the write, streams the data and closes the burst with a Burst Terminate. It then leaves the bus deselected for at least one clock before it will take another request.

Address and data share the bus, so the first data halfword can only appear one clock after the Write command. The block therefore sends the column minus one with the Write command and holds both byte masks high in that cycle. As a result, the first halfword that is really written lands on the requested column. CAS latency is fixed at 2. If the data source falls behind in the middle of a burst, the burst is cut short with a Burst Terminate and an underrun flag is raised.

Top module: `sdram_wr_burst`

## Requirements
- R1: After reset, and whenever no access is in progress, the bus is deselected: sdCke=1, {sdCsN,sdRasN,sdCasN,sdWeN}=4'b1111, sdDqm=2'b11, sdAdOe=0, and reqReady=1.
- R2: A request accepted at a clock edge (reqValid and reqReady both high) puts Activate ({sdCsN,sdRasN,sdCasN,sdWeN}=4'b0011) on the bus in the next cycle, with sdAd equal to reqRow and sdAdOe=1.
- R3: The cycle after Activate carries NOP (4'b0111) with sdAdOe=0, and the Write command (4'b0100) comes exactly two cycles after Activate.
- R4: During the Write command, sdAd carries the requested column minus one, modulo 2^16 (column 0 is sent as 16'hFFFF).
- R5: During the Write command, sdDqm is 2'b11.
- R6: Each cycle after the Write command that carries data shows NOP (4'b0111), sdDqm=2'b00, sdAdOe=1 and sdAd equal to the next halfword. The halfwords appear in the order they were accepted. A halfword is accepted at an edge where wrReady and wrValid are both high, and wrReady is high in the Write cycle and in every data cycle except the last.
- R7: A burst writes reqLenM1+1 halfwords, from 1 up to 2^LEN_W. No halfword beyond that count is accepted.
- R8: Burst Terminate (4'b0110) is issued in the cycle right after the last data cycle, with sdDqm=2'b11 and sdAdOe=0.
- R9: The cycle after Burst Terminate is deselected (4'b1111, sdDqm=2'b11), and reqReady is high again in that cycle. reqReady is low from Activate through Burst Terminate. The next Activate can come, at the earliest, two cycles after Burst Terminate.
- R10: If wrValid is low in a cycle where wrReady is high, the next cycle carries Burst Terminate in place of a data cycle. In that cycle underrun is high and wrReady is low. underrun is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the SDRAM clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request offered |
| reqReady | output | 1 | Request can be taken (idle) |
| reqRow | input | 16 | Row address |
| reqCol | input | 16 | Column of the first halfword |
| reqLenM1 | input | LEN_W | Halfword count minus one |
| wrValid | input | 1 | Write halfword offered |
| wrReady | output | 1 | Halfword taken at this edge if valid |
| wrData | input | 16 | Write halfword |
| underrun | output | 1 | Burst cut short for missing data |
| sdCke | output | 1 | Clock enable, held high |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | 2 | Byte masks, high blocks the write |
| sdAd | output | 16 | Shared address/data bus value |
| sdAdOe | output | 1 | Bus drive enable |

## Verification
The bench targets the edges of the address arithmetic and the burst length. Column 0 has to come out as 16'hFFFF; a design that forgets the minus one, or that does not wrap, would write every halfword one place off. Single-halfword and maximum-length bursts are both checked, because an off-by-one in the length counter would add or drop a data cycle before the terminate. Underruns are forced both on the very first halfword and in mid-burst; a sequencer that waited instead of terminating would keep the masks low and write stale bus data. Back-to-back requests check that exactly one deselected cycle separates the accesses, and that the row is latched at acceptance rather than read later.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_TERM  = 4'b0110;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_GAP, S_WRCMD, S_DATA, S_TERM
  } seqState_e;

  // What the bus shall show in the cycle after the coming edge
  typedef enum logic [2:0] {
    K_DESEL, K_ACT, K_NOP, K_WRITE, K_BEAT, K_TERM
  } busKind_e;

  typedef struct packed {
    logic     loadReq;
    busKind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
  import sdw_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqLenM1,
  input  logic             wrValid,
  output logic             wrReady,
  output ctrlStrobe_t      strobe,
  output logic             underrun
);

  localparam int REM_W = LEN_W + 1;

  seqState_e        state, stNext;
  logic [REM_W-1:0] remaining, remNext;
  logic             underrunNext;

  always_comb begin
    stNext       = state;
    remNext      = remaining;
    underrunNext = 1'b0;
    reqReady     = 1'b0;
    wrReady      = 1'b0;
    strobe       = '{loadReq: 1'b0, kind: K_DESEL};
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stNext         = S_ACT;
          remNext        = {1'b0, reqLenM1} + REM_W'(1);
          strobe.loadReq = 1'b1;
          strobe.kind    = K_ACT;
        end
      end
      S_ACT: begin
        stNext      = S_GAP;
        strobe.kind = K_NOP;
      end
      S_GAP: begin
        stNext      = S_WRCMD;
        strobe.kind = K_WRITE;
      end
      S_WRCMD, S_DATA: begin
        if (remaining == '0) begin
          stNext      = S_TERM;
          strobe.kind = K_TERM;
        end else begin
          wrReady = 1'b1;
          if (wrValid) begin
            stNext      = S_DATA;
            strobe.kind = K_BEAT;
            remNext     = remaining - REM_W'(1);
          end else begin
            stNext       = S_TERM;
            strobe.kind  = K_TERM;
            underrunNext = 1'b1;
          end
        end
      end
      S_TERM: begin
        stNext      = S_IDLE;
        strobe.kind = K_DESEL;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      underrun  <= 1'b0;
    end else begin
      state     <= stNext;
      remaining <= remNext;
      underrun  <= underrunNext;
    end
  end

  // R10: an underrun flag only accompanies the terminate cycle
  assert_underrun_term_R10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (state == S_TERM));

  // R7: a burst that ends normally has used up its whole count
  assert_len_consumed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TERM && !underrun) |-> (remaining == '0));

  // R9: after terminate the sequencer is ready for a new request
  assert_ready_after_term_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TERM) |=> (reqReady && !wrReady));

endmodule

// File: rtl/sdw_datapath.sv
module sdw_datapath
  import sdw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BUS_W-1:0]  reqRow,
  input  logic [BUS_W-1:0]  reqCol,
  input  logic [BUS_W-1:0]  wrData,
  output logic [3:0]        cmd,
  output logic [BUS_W/8-1:0] dqm,
  output logic [BUS_W-1:0]  ad,
  output logic              adOe
);

  localparam int MASK_W = BUS_W / 8;

  logic [BUS_W-1:0] colR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colR <= '0;
    end else if (strobe.loadReq) begin
      colR <= reqCol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd  <= CMD_DESEL;
      dqm  <= '1;
      ad   <= '0;
      adOe <= 1'b0;
    end else begin
      case (strobe.kind)
        K_ACT: begin
          cmd <= CMD_ACT;  dqm <= '1; ad <= reqRow; adOe <= 1'b1;
        end
        K_NOP: begin
          cmd <= CMD_NOP;  dqm <= '1; ad <= '0; adOe <= 1'b0;
        end
        K_WRITE: begin
          // data follows one cycle late on the shared pins, so aim one low
          cmd <= CMD_WRITE; dqm <= '1; ad <= colR - BUS_W'(1); adOe <= 1'b1;
        end
        K_BEAT: begin
          cmd <= CMD_NOP;  dqm <= '0; ad <= wrData; adOe <= 1'b1;
        end
        K_TERM: begin
          cmd <= CMD_TERM; dqm <= '1; ad <= '0; adOe <= 1'b0;
        end
        default: begin
          cmd <= CMD_DESEL; dqm <= '1; ad <= '0; adOe <= 1'b0;
        end
      endcase
    end
  end

  // R3: NOP gap, then Write two cycles after Activate
  assert_act_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT) |=> (cmd == CMD_NOP && !adOe));
  assert_act_to_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT) |-> ##2 (cmd == CMD_WRITE));

  // R4: the column on the Write cycle is one below the latched request
  assert_col_minus_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_WRITE) |-> (ad == $past(colR) - BUS_W'(1)));

  // R5: both masks high while the Write command is on the bus
  assert_write_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_WRITE) |-> (dqm == {MASK_W{1'b1}}));

  // R6: unmasked cycles only follow the Write command or another data cycle
  assert_beat_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dqm == '0) |-> ($past(cmd) == CMD_WRITE || $past(dqm) == '0));

  // R9: terminate is followed by a deselected, masked cycle
  assert_term_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_TERM) |=> (cmd == CMD_DESEL && dqm == {MASK_W{1'b1}}));

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
  import sdw_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [BUS_W-1:0]   reqRow,
  input  logic [BUS_W-1:0]   reqCol,
  input  logic [LEN_W-1:0]   reqLenM1,
  input  logic               wrValid,
  output logic               wrReady,
  input  logic [BUS_W-1:0]   wrData,
  output logic               underrun,
  output logic               sdCke,
  output logic               sdCsN,
  output logic               sdRasN,
  output logic               sdCasN,
  output logic               sdWeN,
  output logic [BUS_W/8-1:0] sdDqm,
  output logic [BUS_W-1:0]   sdAd,
  output logic               sdAdOe
);

  ctrlStrobe_t strobe;
  logic [3:0]  cmd;

  sdw_ctrl #(.LEN_W(LEN_W)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqLenM1 (reqLenM1),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .strobe   (strobe),
    .underrun (underrun)
  );

  sdw_datapath #(.BUS_W(BUS_W)) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqRow (reqRow),
    .reqCol (reqCol),
    .wrData (wrData),
    .cmd    (cmd),
    .dqm    (sdDqm),
    .ad     (sdAd),
    .adOe   (sdAdOe)
  );

  assign sdCke = 1'b1;
  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;

endmodule

// File: tb/sdram_wr_burst_test.sv
module sdram_wr_burst_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady;
  logic [15:0] reqRow, reqCol;
  logic [7:0]  reqLenM1;
  logic        wrValid, wrReady;
  logic [15:0] wrData;
  logic        underrun, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdAdOe;
  logic [1:0]  sdDqm;
  logic [15:0] sdAd;
  logic [3:0]  busCmd;

  int  total = 0;
  int  failed = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  assign busCmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  sdram_wr_burst uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqCol(reqCol), .reqLenM1(reqLenM1),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData), .underrun(underrun),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdDqm(sdDqm), .sdAd(sdAd), .sdAdOe(sdAdOe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int seed, input int k);
    return 16'(seed * 16'h1357 + k * 16'h0101 + 16'h00A5);
  endfunction

  task automatic chkIdle(input string req);
    chk(req, "cke", sdCke, 1);
    chk(req, "cmd deselect", busCmd, 4'b1111);
    chk(req, "dqm", sdDqm, 2'b11);
    chk(req, "adOe", sdAdOe, 0);
    chk(req, "reqReady", reqReady, 1);
    chk("R10", "underrun idle", underrun, 0);
  endtask

  // Starts and finishes at a negedge of an idle cycle.
  task automatic runBurst(input logic [15:0] row, input logic [15:0] col,
                          input int lenM1, input int stallAt, input int seed);
    bit stopped = 1'b0;
    chk("R9", "reqReady before accept", reqReady, 1);
    reqValid = 1'b1; reqRow = row; reqCol = col; reqLenM1 = 8'(lenM1);
    @(negedge clk);
    reqValid = 1'b0; reqRow = 16'h0; reqCol = 16'h0; reqLenM1 = 8'h0;
    chk("R2", "activate cmd", busCmd, 4'b0011);
    chk("R2", "row on bus", sdAd, row);
    chk("R2", "adOe", sdAdOe, 1);
    chk("R9", "reqReady busy", reqReady, 0);
    @(negedge clk);
    chk("R3", "gap nop", busCmd, 4'b0111);
    chk("R3", "gap adOe", sdAdOe, 0);
    @(negedge clk);
    chk("R3", "write cmd", busCmd, 4'b0100);
    chk("R4", "column minus one", sdAd, 16'(col - 16'd1));
    chk("R5", "write masks", sdDqm, 2'b11);
    chk("R6", "wrReady first", wrReady, 1);
    chk("R9", "reqReady busy", reqReady, 0);
    for (int k = 0; k <= lenM1; k++) begin
      if (k == stallAt) begin
        wrValid = 1'b0;
      end else begin
        wrValid = 1'b1;
        wrData  = pat(seed, k);
      end
      if (k > 0) chk("R6", "wrReady mid", wrReady, 1);
      @(negedge clk);
      if (k == stallAt) begin
        chk("R10", "terminate on underrun", busCmd, 4'b0110);
        chk("R10", "underrun flag", underrun, 1);
        chk("R10", "masks on underrun", sdDqm, 2'b11);
        chk("R10", "no more taken", wrReady, 0);
        stopped = 1'b1;
        break;
      end
      chk("R6", "beat cmd", busCmd, 4'b0111);
      chk("R6", "beat masks", sdDqm, 2'b00);
      chk("R6", "beat data", sdAd, pat(seed, k));
      chk("R6", "beat adOe", sdAdOe, 1);
      chk("R10", "no underrun", underrun, 0);
    end
    if (!stopped) begin
      wrValid = 1'b1;
      wrData  = 16'hDEAD;
      chk("R7", "no extra halfword", wrReady, 0);
      @(negedge clk);
      chk("R8", "terminate cmd", busCmd, 4'b0110);
      chk("R8", "terminate masks", sdDqm, 2'b11);
      chk("R8", "terminate adOe", sdAdOe, 0);
      chk("R10", "no underrun at end", underrun, 0);
      chk("R9", "reqReady at term", reqReady, 0);
    end
    wrValid = 1'b0;
    @(negedge clk);
    chkIdle("R9");
  endtask

  task automatic testReset();
    rstN = 1'b0; reqValid = 1'b0; wrValid = 1'b0;
    reqRow = '0; reqCol = '0; reqLenM1 = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");
  endtask

  task automatic testIdleHold();
    repeat (3) begin
      @(negedge clk);
      chkIdle("R1");
    end
  endtask

  task automatic testSingle();    runBurst(16'h1234, 16'h0010, 0, -1, 1);  endtask // R7 min
  task automatic testColWrap();   runBurst(16'h0ABC, 16'h0000, 3, -1, 2);  endtask // R4 wrap
  task automatic testStallMid();  runBurst(16'h0101, 16'h0200, 4, 2, 3);   endtask // R10
  task automatic testStallFirst(); runBurst(16'h0F0F, 16'h0005, 2, 0, 4);  endtask // R10
  task automatic testBackToBack();                                          // R9
    runBurst(16'h2222, 16'h0033, 1, -1, 5);
    runBurst(16'h3333, 16'h0044, 2, -1, 6);
  endtask
  task automatic testLongest();   runBurst(16'hFFFF, 16'h8000, 255, -1, 7); endtask // R7 max

  initial begin
    testReset();
    testIdleHold();
    testSingle();
    testColWrap();
    testStallMid();
    testStallFirst();
    testBackToBack();
    testLongest();
    testIdleHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule